// File: doc/BRIEF.md
# Sampling Converter Serial Port Sequencer

This block is the device-side digital front end of a 12-bit sampling converter. It serves a four-wire full-duplex serial link (active-low chip select, shift clock, data in, data out) that is oversampled by the block's own clock. During each chip-select frame it takes in an 8-bit configuration word and shifts out, at the same time, the result of the conversion that the previous frame asked for. The result is formatted with the coding, bit order and output length chosen by the word that requested it.

When a frame closes with a complete configuration word, the block issues a one-cycle start pulse to the converter along with the four-bit channel address. It then waits for the converter's done strobe and formats and stores the sample for the next frame. The analog section is outside this block: it is represented by the start pulse, the channel code, a done strobe and a 12-bit offset-binary sample.

Top module: `adc_serial_port`

## Requirements
- R1: While chip select is high, the output enable is low and data out is 0. While chip select is low, the output enable is high.
- R2: After chip select falls, the configuration word is taken from data in on the first 8 rising shift-clock edges, first bit first. In order of arrival the bits are: single/differential, odd/sign, select1, select0, unipolar (1) / bipolar (0), MSB-first (1) / LSB-first (0), length bit 1, length bit 0.
- R3: Data in is ignored on every rising shift-clock edge after the eighth one in a frame.
- R4: The first result bit is presented before the first rising edge of a frame. Data out changes only after falling shift-clock edges, advancing one bit per falling edge.
- R5: The result shifted out in a frame comes from the conversion requested by the previous completed frame. A conversion that finishes in the same clock in which a frame start is detected is the one shifted out in that frame.
- R6: MSB-first shifts B11 down to B0. LSB-first shifts B0 up to B11.
- R7: Length code 00 gives 8 bits, the upper bits B11..B4. Codes 01 and 10 give 12 bits. Code 11 gives 16 bits: four zeros after the data when MSB-first, and four zeros before it when LSB-first.
- R8: In bipolar mode B11 of the sample is inverted, which gives two's complement. In unipolar mode the sample passes unchanged.
- R9: After the selected length, data out is 0 for the rest of the frame.
- R10: After reset the stored result is 0, formatted as unipolar, MSB-first, 12 bits, and no start pulse is issued.
- R11: A frame that ends after fewer than 8 rising edges starts no conversion and leaves the stored result unchanged.
- R12: A completed frame produces a single-cycle start pulse once chip select has risen. The channel output carries the first four configuration bits and holds them until the conversion is done.
- R13: A frame that completes while a conversion is in progress starts nothing, and the pending conversion's result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial shift clock |
| din_i | input | 1 | Serial configuration data |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable for the data out pad |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| conv_chan_o | output | 4 | Channel address for the conversion |
| conv_done_i | input | 1 | Converter done strobe, one cycle |
| sample_i | input | 12 | Offset-binary sample, valid with done |

## Verification
Two events can land on the same clock edge: the converter's done strobe and the detection of a chip-select fall. When they coincide, the frame snapshot must take the new sample and not the stale one. The bench first holds a conversion busy and runs a frame in that state to show the request is dropped. It then drives the done strobe exactly on the edge where the synchronised chip-select fall is acted on. That frame must shift out the freshly finished result, formatted by the word that requested it.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int unsigned RES_W  = 12;
  localparam int unsigned CFG_W  = 8;
  localparam int unsigned CHAN_W = 4;
  localparam int unsigned PAD_W  = 4;
  localparam int unsigned OUT_W  = RES_W + PAD_W;
  localparam int unsigned TRNC_W = RES_W - PAD_W;
  localparam int unsigned LEN_W  = $clog2(OUT_W + 1);

  typedef enum logic [1:0] {
    WL_SHORT = 2'b00,
    WL_NAT_A = 2'b01,
    WL_NAT_B = 2'b10,
    WL_LONG  = 2'b11
  } wlen_e;

  // field order equals arrival order (first bit = MSB)
  typedef struct packed {
    logic  sgl;
    logic  odd;
    logic  sel1;
    logic  sel0;
    logic  uni;
    logic  msbf;
    wlen_e wl;
  } port_cfg_t;

  localparam port_cfg_t CFG_RESET = '{sgl: 1'b1, odd: 1'b0, sel1: 1'b0, sel0: 1'b0,
                                      uni: 1'b1, msbf: 1'b1, wl: WL_NAT_A};
endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
  parameter int unsigned         N       = 3,
  parameter int unsigned         STAGES  = 2,
  parameter logic [N-1:0]        RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] lvl_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= sig_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stage[s-1].q;
    end
  end

  assign lvl_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/adc_port_fmt.sv
module adc_port_fmt
  import adc_port_pkg::*;
(
  input  port_cfg_t         cfg_i,
  input  logic [RES_W-1:0]  sample_i,
  output logic [OUT_W-1:0]  vec_o,   // [OUT_W-1] leaves first
  output logic [LEN_W-1:0]  len_o
);
  logic [RES_W-1:0] coded;
  logic [RES_W-1:0] rev;

  // R8: bipolar flips the sign bit of the offset-binary sample
  assign coded = cfg_i.uni ? sample_i : {~sample_i[RES_W-1], sample_i[RES_W-2:0]};

  for (genvar i = 0; i < RES_W; i++) begin : g_rev
    assign rev[i] = coded[RES_W-1-i];
  end

  // R6/R7
  always_comb begin
    unique case (cfg_i.wl)
      WL_SHORT: begin
        len_o = LEN_W'(TRNC_W);
        vec_o = cfg_i.msbf ? {coded[RES_W-1 -: TRNC_W], {(OUT_W-TRNC_W){1'b0}}}
                           : {rev[TRNC_W-1:0],          {(OUT_W-TRNC_W){1'b0}}};
      end
      WL_LONG: begin
        len_o = LEN_W'(OUT_W);
        vec_o = cfg_i.msbf ? {coded, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, rev};
      end
      default: begin
        len_o = LEN_W'(RES_W);
        vec_o = cfg_i.msbf ? {coded, {PAD_W{1'b0}}} : {rev, {PAD_W{1'b0}}};
      end
    endcase
  end
endmodule

// File: rtl/adc_port_frame.sv
module adc_port_frame
  import adc_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_act_i,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  input  logic             din_i,
  input  logic [OUT_W-1:0] res_vec_i,
  input  logic [LEN_W-1:0] res_len_i,
  output logic             req_o,
  output port_cfg_t        cfg_o,
  output logic             dout_o,
  output logic             dout_oe_o
);
  localparam int unsigned CNT_W = $clog2(CFG_W + 1);

  logic [CNT_W-1:0] in_cnt_q;
  logic [CFG_W-1:0] cfg_sr_q;
  logic [LEN_W-1:0] out_cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [OUT_W-1:0] vec_q;
  logic             word_full;

  assign word_full = (in_cnt_q == CNT_W'(CFG_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt_q  <= '0;
      cfg_sr_q  <= '0;
      out_cnt_q <= '0;
      len_q     <= '0;
      vec_q     <= '0;
    end else if (cs_fall_i) begin
      // snapshot includes a result finishing this cycle (R5)
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
      vec_q     <= res_vec_i;
      len_q     <= res_len_i;
    end else if (cs_rise_i) begin
      vec_q     <= '0;
    end else if (cs_act_i) begin
      if (sclk_rise_i && !word_full) begin   // R2/R3
        cfg_sr_q <= {cfg_sr_q[CFG_W-2:0], din_i};
        in_cnt_q <= in_cnt_q + 1'b1;
      end
      if (sclk_fall_i) begin                 // R4
        vec_q <= {vec_q[OUT_W-2:0], 1'b0};
        if (out_cnt_q != '1) out_cnt_q <= out_cnt_q + 1'b1;
      end
    end
  end

  assign req_o     = cs_rise_i && word_full;  // R11
  assign cfg_o     = port_cfg_t'(cfg_sr_q);
  assign dout_oe_o = cs_act_i;
  assign dout_o    = cs_act_i && vec_q[OUT_W-1] && (out_cnt_q < len_q);  // R1/R9
endmodule

// File: rtl/adc_port_conv.sv
module adc_port_conv
  import adc_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  port_cfg_t         cfg_i,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  sample_i,
  output logic              conv_start_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  output logic [OUT_W-1:0]  res_vec_o,
  output logic [LEN_W-1:0]  res_len_o
);
  logic              busy_q;
  logic              start_q;
  logic [CHAN_W-1:0] chan_q;
  port_cfg_t         pend_q;
  logic [OUT_W-1:0]  res_vec_q;
  logic [LEN_W-1:0]  res_len_q;
  logic [OUT_W-1:0]  fmt_vec;
  logic [LEN_W-1:0]  fmt_len;
  logic              finish;

  adc_port_fmt i_fmt (
    .cfg_i    (pend_q),
    .sample_i (sample_i),
    .vec_o    (fmt_vec),
    .len_o    (fmt_len)
  );

  assign finish = conv_done_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      start_q   <= 1'b0;
      chan_q    <= '0;
      pend_q    <= CFG_RESET;
      res_vec_q <= '0;                     // R10
      res_len_q <= LEN_W'(RES_W);
    end else begin
      start_q <= 1'b0;
      if (finish) begin
        busy_q    <= 1'b0;
        res_vec_q <= fmt_vec;
        res_len_q <= fmt_len;
      end
      if (req_i && !busy_q) begin          // R13: dropped while busy
        busy_q  <= 1'b1;
        start_q <= 1'b1;
        chan_q  <= {cfg_i.sgl, cfg_i.odd, cfg_i.sel1, cfg_i.sel0};
        pend_q  <= cfg_i;
      end
    end
  end

  assign conv_start_o = start_q;
  assign conv_chan_o  = chan_q;
  assign res_vec_o    = finish ? fmt_vec : res_vec_q;
  assign res_len_o    = finish ? fmt_len : res_len_q;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              conv_start_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  sample_i
);
  logic [2:0]       pin_lvl;
  logic [1:0]       prev_q;
  logic             cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic             req;
  port_cfg_t        req_cfg;
  logic [OUT_W-1:0] res_vec;
  logic [LEN_W-1:0] res_len;

  adc_port_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({cs_ni, sclk_i, din_i}),
    .lvl_o  (pin_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 2'b10;
    else         prev_q <= pin_lvl[2:1];

  assign cs_fall   =  prev_q[1] & ~pin_lvl[2];
  assign cs_rise   = ~prev_q[1] &  pin_lvl[2];
  assign sclk_rise = ~prev_q[0] &  pin_lvl[1];
  assign sclk_fall =  prev_q[0] & ~pin_lvl[1];

  adc_port_frame i_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_act_i    (~pin_lvl[2]),
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .din_i       (pin_lvl[0]),
    .res_vec_i   (res_vec),
    .res_len_i   (res_len),
    .req_o       (req),
    .cfg_o       (req_cfg),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o)
  );

  adc_port_conv i_conv (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req),
    .cfg_i        (req_cfg),
    .conv_done_i  (conv_done_i),
    .sample_i     (sample_i),
    .conv_start_o (conv_start_o),
    .conv_chan_o  (conv_chan_o),
    .res_vec_o    (res_vec),
    .res_len_o    (res_len)
  );
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       sclk_i,
  input logic       dout_oe_o,
  input logic       conv_start_o,
  input logic [3:0] conv_chan_o,
  input logic       conv_done_i
);
  logic       busy_q;
  logic       sclk_q, cs_q;
  logic [3:0] rise_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      rise_cnt_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
      if (conv_start_o)     busy_q <= 1'b1;
      else if (conv_done_i) busy_q <= 1'b0;
      if (cs_q && !cs_ni) rise_cnt_q <= '0;
      else if (!cs_ni && sclk_i && !sclk_q && rise_cnt_q != 4'hF)
        rise_cnt_q <= rise_cnt_q + 1'b1;
    end
  end

  assert_start_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_start_after_frame_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !$past(dout_oe_o) && $past(dout_oe_o, 2));

  assert_chan_held_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !conv_start_o |-> $stable(conv_chan_o));

  assert_no_start_busy_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !busy_q);

  assert_full_word_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> rise_cnt_q >= 4'd8);
endmodule

bind adc_serial_port adc_serial_port_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .sclk_i       (sclk_i),
  .dout_oe_o    (dout_oe_o),
  .conv_start_o (conv_start_o),
  .conv_chan_o  (conv_chan_o),
  .conv_done_i  (conv_done_i)
);

// File: tb/test_adc_serial_port.sv
`timescale 1ns/1ps
module test_adc_serial_port;
  localparam int H = 6;  // clocks per shift-clock half period

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, dout_oe, conv_start, conv_done = 1'b0;
  logic [3:0]  conv_chan;
  logic [11:0] sample = '0;

  always #2.5 clk = ~clk;

  adc_serial_port i_adc_serial_port (
    .clk_i (clk), .rst_ni (rst_n), .cs_ni (cs_n), .sclk_i (sclk), .din_i (din),
    .dout_o (dout), .dout_oe_o (dout_oe), .conv_start_o (conv_start),
    .conv_chan_o (conv_chan), .conv_done_i (conv_done), .sample_i (sample)
  );

  int n_chk = 0, n_fail = 0, starts = 0;
  bit manual = 1'b0;
  logic [11:0] model_s = '0;
  logic [3:0]  last_chan = '0;
  logic [7:0]  prev_cfg = 8'h8D;
  logic [11:0] prev_s = '0;

  // {cfg, sample}
  localparam logic [19:0] VEC [8] = '{
    {8'h8D, 12'hA5C}, {8'hE4, 12'h3C7}, {8'h9B, 12'hB61}, {8'h5F, 12'h7F0},
    {8'h22, 12'h801}, {8'hC8, 12'h1E3}, {8'h37, 12'hFFF}, {8'hA1, 12'h000}};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // expected serial sequence, first bit in [15]
  function automatic logic [15:0] exp_vec(input logic [7:0] cfg, input logic [11:0] s);
    logic [11:0] v;
    int len;
    v = cfg[3] ? s : {~s[11], s[10:0]};
    len = (cfg[1:0] == 2'b00) ? 8 : (cfg[1:0] == 2'b11) ? 16 : 12;
    exp_vec = '0;
    for (int k = 0; k < len; k++) begin
      if (cfg[2]) exp_vec[15-k] = (k < 12) ? v[11-k] : 1'b0;
      else if (len == 8)  exp_vec[15-k] = v[4+k];
      else if (len == 12) exp_vec[15-k] = v[k];
      else                exp_vec[15-k] = (k < 4) ? 1'b0 : v[k-4];
    end
  endfunction

  // converter model
  initial forever begin
    @(negedge clk);
    if (conv_start) begin
      starts++;
      last_chan = conv_chan;
      if (!manual) begin
        repeat (4) @(negedge clk);
        sample = model_s;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic do_frame(input logic [7:0] cfg, input int nclk, input bit coin,
                          input logic [11:0] coin_s, output logic [15:0] got,
                          output bit stable_ok, output bit oe_ok);
    logic a;
    got = '0; stable_ok = 1'b1; oe_ok = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    if (coin) begin
      repeat (2) @(negedge clk);
      sample = coin_s;
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
    end
    for (int i = 0; i < nclk; i++) begin
      din = (i < 8) ? cfg[7-i] : ~cfg[7-(i%8)];  // junk after the word
      repeat (H) @(negedge clk);
      a = dout;
      if (i < 16) got[15-i] = a;
      if (!dout_oe) oe_ok = 1'b0;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (dout !== a) stable_ok = 1'b0;
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cfg, input logic [11:0] s, input int nclk, input string tag);
    logic [15:0] got, exp, mask;
    bit st, oe;
    int sb;
    sb = starts;
    model_s = s;
    exp = exp_vec(prev_cfg, prev_s);
    do_frame(cfg, nclk, 1'b0, '0, got, st, oe);
    mask = (nclk >= 16) ? 16'hFFFF : ~(16'hFFFF >> nclk);
    check((got & mask) == (exp & mask), tag, got & mask, exp & mask);
    check(st, "R4 dout stable across rising edge", st, 1);
    check(oe && !dout_oe && !dout, "R1 output enable", {oe, dout_oe, dout}, 3'b100);
    if (nclk >= 8) begin
      check(starts == sb + 1, "R12 one start per frame", starts - sb, 1);
      check(last_chan == cfg[7:4], "R12 channel", last_chan, cfg[7:4]);
      prev_cfg = cfg; prev_s = s;
    end else begin
      check(starts == sb, "R11 aborted frame starts nothing", starts - sb, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] got;
    bit st, oe;
    int sb;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!dout_oe && !dout && !conv_start, "R10 reset outputs", {dout_oe, dout, conv_start}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!dout_oe && !conv_start, "R10 idle after reset", {dout_oe, conv_start}, 0);

    // table walk: R2 R5 R6 R7 R8 R9; first frame returns the R10 zero result
    for (int k = 0; k < 8; k++)
      xfer(VEC[k][19:12], VEC[k][11:0], 16, k == 0 ? "R10 R5 first result zero" : "R5 R6 R7 R8 R9 result");

    // R3: junk after eighth edge must not alter the word
    xfer(8'h4E, 12'h9A6, 20, "R5 table tail");
    xfer(8'h8D, 12'h123, 16, "R3 junk bits ignored");

    // R11: abort after five edges, result kept
    xfer(8'h17, 12'hFFF, 5, "R11 partial frame result");
    xfer(8'hB3, 12'h5A5, 16, "R11 previous result kept");

    // R13 and same-cycle done/frame start
    manual = 1'b1;
    sb = starts;
    xfer(8'hD9, 12'h6C3, 16, "R5 before busy");           // request A, left busy
    do_frame(8'h0E, 16, 1'b0, '0, got, st, oe);           // completes while busy
    check(starts == sb + 1, "R13 no start while busy", starts - sb, 1);
    check(got == exp_vec(8'hB3, 12'h5A5), "R13 busy frame result", got, exp_vec(8'hB3, 12'h5A5));
    manual = 1'b0;
    model_s = 12'h2D4;
    do_frame(8'h6F, 16, 1'b1, 12'h6C3, got, st, oe);      // done coincides with frame start
    check(got == exp_vec(8'hD9, 12'h6C3), "R5 coincident done", got, exp_vec(8'hD9, 12'h6C3));
    check(starts == sb + 2, "R12 start after busy clears", starts - sb, 2);
    prev_cfg = 8'h6F; prev_s = 12'h2D4;
    xfer(8'h8D, 12'h000, 16, "R5 after coincident frame");

    finish_run();
  end
endmodule